// File: doc/BRIEF.md
# Extended Multiply Divide Unit

This block is a multi-cycle arithmetic helper for a 16-bit core. It takes the current values of the core's D, X and Y registers, an operation code and a start strobe. It returns new values for all three registers, the N, Z, V and C condition flags, and a one-cycle done pulse.

Four operations are supported:

- a signed multiply;
- a signed 16/16 divide;
- an unsigned 32/16 divide;
- a signed 32/16 divide.

The 32-bit operands and results use the register pair Y:D, with Y as the upper half. The core writes back all three register outputs and the flags when done pulses. Registers that an operation does not change are returned with their original values.

The divides use a restoring shift-subtract loop that produces one quotient bit per cycle. This loop works on magnitudes, and the signs are applied afterwards. The quotient is truncated toward zero, and the remainder takes the sign of the dividend. The multiply and any divide by zero finish after one cycle.

Top module: `xmuldiv`

## Requirements
- R1: After reset, d_out, x_out and y_out are zero, all four flags are zero and done is low.
- R2: The op encoding is 2'b00 signed 16/16 divide, 2'b01 unsigned 32/16 divide, 2'b10 signed 32/16 divide and 2'b11 signed multiply. done is high for exactly one cycle. It rises 1 cycle after the start edge for a multiply or a zero divisor, and 33 cycles after it for any other divide.
- R3: Signed 16/16 divide: D divided by X, both signed. x_out is the low 16 bits of the truncated quotient, d_out is the remainder with the sign of D, and y_out equals Y.
- R4: Unsigned 32/16 divide: {Y,D} divided by X, both unsigned. y_out is the low 16 bits of the quotient, d_out is the remainder, and x_out equals X.
- R5: Signed 32/16 divide: {Y,D} divided by X, both signed. y_out is the low 16 bits of the truncated quotient, d_out is the remainder with the dividend's sign, and x_out equals X.
- R6: On any divide with X equal to zero, C is 1, N, Z and V are 0, and d_out, x_out and y_out equal D, X and Y.
- R7: On a divide with a nonzero divisor, C is 0. Z is 1 exactly when the full quotient is zero, and N equals bit 15 of the 16-bit quotient written out.
- R8: V is set on an unsigned divide when the quotient exceeds 65535. On a signed divide, V is set when the quotient lies outside -32768..32767.
- R9: Multiply: the signed product of D and Y, with d_out holding product bits 15:0 and y_out holding bits 31:16. x_out equals X. Z is set when the product is zero, N is product bit 31, C is product bit 15 and V is 0.
- R10: A start pulse while an operation is in progress is ignored, and the running operation's results and timing are unaffected.
- R11: Outputs and flags keep their values from one operation's completion until the next operation's completion, whatever the inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only when idle |
| op | input | 2 | Operation select |
| d_in | input | 16 | D register value |
| x_in | input | 16 | X register value |
| y_in | input | 16 | Y register value |
| d_out | output | 16 | New D value |
| x_out | output | 16 | New X value |
| y_out | output | 16 | New Y value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry / divide-by-zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Results are due 1 clock edge after the start edge for a multiply or a zero divisor, and 33 edges after it for any other divide. The bench derives this latency from the operation and the divisor before it drives the start. On every falling edge up to that point it checks that done is low. It compares all outputs and flags on the falling edge just after the due edge, and confirms that done has dropped one cycle later. A hold phase then changes the inputs without a start and checks that the results are unchanged. Pulses of start during a running divide are checked against the same exact latency.

// File: rtl/xmuldiv.sv
module xmuldiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] d_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         done
);

  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW);
  localparam logic [1:0] OP_SDIV = 2'd0;
  localparam logic [1:0] OP_UDIV = 2'd1;
  localparam logic [1:0] OP_LDIV = 2'd2;
  localparam logic [1:0] OP_MUL  = 2'd3;
  localparam logic [DW-1:0] POS_LIM = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic [DW-1:0] NEG_LIM = POS_LIM + 1'b1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t        state;
  logic [1:0]    op_r;
  logic [W-1:0]  dr, xr, yr;
  logic [DW-1:0] acc;
  logic [W-1:0]  rem;
  logic [W-1:0]  dvs;
  logic [CW-1:0] cnt;
  logic          qneg, rneg;

  logic          signed_op;
  logic [DW-1:0] dvd_raw;
  logic          dvd_neg, dvs_neg;
  assign signed_op = (op != OP_UDIV);
  assign dvd_raw   = (op == OP_SDIV) ? {{W{d_in[W-1]}}, d_in} : {y_in, d_in};
  assign dvd_neg   = signed_op & dvd_raw[DW-1];
  assign dvs_neg   = signed_op & x_in[W-1];

  logic [W:0] trial;
  logic       fits;
  assign trial = {rem, acc[DW-1]};
  assign fits  = trial >= {1'b0, dvs};

  logic signed [DW-1:0] prod;
  logic [W-1:0]         q_lo, r_lo;
  logic                 q_ovf, divz;
  assign prod  = $signed(dr) * $signed(yr);
  assign q_lo  = qneg ? W'(-acc[W-1:0]) : acc[W-1:0];
  assign r_lo  = rneg ? W'(-rem) : rem;
  assign q_ovf = (op_r == OP_UDIV) ? (|acc[DW-1:W])
               : (qneg ? (acc > NEG_LIM) : (acc > POS_LIM));
  assign divz  = (xr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_r  <= OP_SDIV;
      dr    <= '0;
      xr    <= '0;
      yr    <= '0;
      acc   <= '0;
      rem   <= '0;
      dvs   <= '0;
      cnt   <= '0;
      qneg  <= 1'b0;
      rneg  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_r <= op;
          dr   <= d_in;
          xr   <= x_in;
          yr   <= y_in;
          acc  <= dvd_neg ? DW'(-dvd_raw) : dvd_raw;
          dvs  <= dvs_neg ? W'(-x_in) : x_in;
          rem  <= '0;
          cnt  <= '0;
          qneg <= dvd_neg ^ dvs_neg;
          rneg <= dvd_neg;
          state <= (op == OP_MUL || x_in == '0) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          rem <= fits ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
          acc <= {acc[DW-2:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_out  <= '0;
      x_out  <= '0;
      y_out  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      if (state == S_FIN) begin
        if (op_r == OP_MUL) begin
          d_out  <= prod[W-1:0];
          y_out  <= prod[DW-1:W];
          x_out  <= xr;
          flag_n <= prod[DW-1];
          flag_z <= (prod == '0);
          flag_v <= 1'b0;
          flag_c <= prod[W-1];
        end else if (divz) begin
          d_out  <= dr;
          x_out  <= xr;
          y_out  <= yr;
          flag_n <= 1'b0;
          flag_z <= 1'b0;
          flag_v <= 1'b0;
          flag_c <= 1'b1;
        end else begin
          d_out  <= r_lo;
          if (op_r == OP_SDIV) begin
            x_out <= q_lo;
            y_out <= yr;
          end else begin
            x_out <= xr;
            y_out <= q_lo;
          end
          flag_n <= q_lo[W-1];
          flag_z <= (acc == '0);
          flag_v <= q_ovf;
          flag_c <= 1'b0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_r != OP_MUL && xr == '0 |-> flag_c && d_out == dr && x_out == xr && y_out == yr); // R6
  AST_DIV_OK_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_r != OP_MUL && xr != '0 |-> !flag_c); // R7
  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_r == OP_MUL |-> flag_c == d_out[W-1] && flag_n == y_out[W-1] && !flag_v); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |=> $stable(op_r) && $stable(xr)); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_FIN |=> $stable(d_out) && $stable(x_out) && $stable(y_out) && $stable(flag_c)); // R11

endmodule

// File: tb/xmuldiv_test.sv
`timescale 1ns/1ps
module xmuldiv_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] op = 0;
  logic [15:0] d_in = 0, x_in = 0, y_in = 0;
  logic [15:0] d_out, x_out, y_out;
  logic flag_n, flag_z, flag_v, flag_c, done;
  int checks = 0, errors = 0;
  int cyc = 0;

  xmuldiv uut (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .d_in(d_in), .x_in(x_in),
    .y_in(y_in), .d_out(d_out), .x_out(x_out), .y_out(y_out), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .done(done));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [15:0] ed, ex, ey;
  logic en, ez, ev, ec;
  int lat;
  string oreq;

  task automatic model(input logic [1:0] o, input logic [15:0] d, input logic [15:0] x, input logic [15:0] y);
    longint a, b, q, r, p;
    ed = d; ex = x; ey = y; en = 0; ez = 0; ev = 0; ec = 0;
    oreq = (o == 0) ? "R3" : (o == 1) ? "R4" : (o == 2) ? "R5" : "R9";
    if (o == 2'd3) begin
      p = longint'($signed(d)) * longint'($signed(y));
      ed = p[15:0]; ey = p[31:16];
      ez = (p[31:0] == 0); en = p[31]; ec = p[15];
      lat = 1;
      return;
    end
    if (x == 0) begin
      ec = 1; lat = 1;
      return;
    end
    lat = 33;
    if (o == 2'd0) begin
      a = longint'($signed(d)); b = longint'($signed(x));
    end else if (o == 2'd1) begin
      a = longint'({32'd0, y, d}); b = longint'({48'd0, x});
    end else begin
      a = longint'($signed({y, d})); b = longint'($signed(x));
    end
    q = a / b; r = a % b;
    ed = r[15:0];
    if (o == 2'd0) ex = q[15:0]; else ey = q[15:0];
    ez = (q == 0); en = q[15];
    ev = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
  endtask

  task automatic check_outs(input bit divop);
    chk(oreq, {16'd0, d_out}, {16'd0, ed});
    chk(oreq, {16'd0, x_out}, {16'd0, ex});
    chk(oreq, {16'd0, y_out}, {16'd0, ey});
    chk(divop ? (ec ? "R6" : "R7") : "R9", {31'd0, flag_c}, {31'd0, ec});
    chk(divop ? "R7" : "R9", {30'd0, flag_n, flag_z}, {30'd0, en, ez});
    chk(divop ? "R8" : "R9", {31'd0, flag_v}, {31'd0, ev});
  endtask

  task automatic run_op(input logic [1:0] o, input logic [15:0] d, input logic [15:0] x,
                        input logic [15:0] y, input bit poke);
    model(o, d, x, y);
    @(negedge clk);
    op = o; d_in = d; x_in = x; y_in = y; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < lat; i++) begin
      chk(poke ? "R10" : "R2", {31'd0, done}, 32'd0);
      if (poke && (i == 1 || i == 20)) begin
        start = 1; op = ~o; d_in = ~d; x_in = 16'h0000; y_in = y ^ 16'h5a5a;
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
    chk("R2", {31'd0, done}, 32'd1);
    check_outs(o != 2'd3);
    d_in = $urandom; x_in = $urandom; y_in = $urandom; op = $urandom;
    @(negedge clk);
    chk("R2", {31'd0, done}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R11", {d_out, x_out}, {ed, ex});
    chk("R11", {12'd0, y_out, flag_n, flag_z, flag_v, flag_c}, {12'd0, ey, en, ez, ev, ec});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", {d_out, x_out}, 32'd0);
    chk("R1", {11'd0, y_out, flag_n, flag_z, flag_v, flag_c, done}, 32'd0);
    rst_n = 1;
    // R3 signed 16/16
    run_op(2'd0, 16'd7, 16'd2, 16'h1111, 0);
    run_op(2'd0, 16'hFFF9, 16'd2, 16'h2222, 0);
    run_op(2'd0, 16'h8000, 16'hFFFF, 16'h0, 0);
    run_op(2'd0, 16'd0, 16'd5, 16'h3333, 0);
    run_op(2'd0, 16'd1234, 16'd0, 16'h4444, 0);
    // R4 unsigned 32/16
    run_op(2'd1, 16'h5678, 16'h1234, 16'h1234, 0);
    run_op(2'd1, 16'hFFFF, 16'd1, 16'hFFFF, 0);
    run_op(2'd1, 16'h0000, 16'hFFFF, 16'h0001, 0);
    run_op(2'd1, 16'h0005, 16'h0000, 16'h0009, 0);
    // R5 signed 32/16
    run_op(2'd2, 16'h7960, 16'd7, 16'hFFFE, 0);
    run_op(2'd2, 16'h0000, 16'hFFFF, 16'h8000, 0);
    run_op(2'd2, 16'h0000, 16'd2, 16'hFFFF, 0);
    run_op(2'd2, 16'h0000, 16'd2, 16'h0001, 0);
    run_op(2'd2, 16'hFFF9, 16'hFFFE, 16'hFFFF, 0);
    // R9 multiply
    run_op(2'd3, 16'hFFFF, 16'h1, 16'hFFFF, 0);
    run_op(2'd3, 16'h7FFF, 16'h2, 16'h7FFF, 0);
    run_op(2'd3, 16'h8000, 16'h3, 16'h8000, 0);
    run_op(2'd3, 16'h0000, 16'h4, 16'h1234, 0);
    run_op(2'd3, 16'h8000, 16'h5, 16'h0001, 0);
    // R10 start during busy
    run_op(2'd1, 16'h4321, 16'h0017, 16'h0042, 1);
    run_op(2'd0, 16'h8001, 16'h0003, 16'h0000, 1);
    for (int k = 0; k < 80; k++) begin
      logic [1:0] ro;
      logic [15:0] rx;
      ro = $urandom;
      rx = ($urandom % 10 == 0) ? 16'h0 : 16'($urandom);
      if ($urandom % 2 == 0) rx = rx >> ($urandom % 15);
      run_op(ro, 16'($urandom), rx, 16'($urandom), (k % 7) == 3 && ro != 2'd3 && rx != 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule